// File: doc/BRIEF.md
# Fifteen-Cent Vending Credit Controller

This block is a clocked Moore state machine that tracks the money a customer has put into a vending machine. Every item costs 15 cents, and the machine accepts only 5-cent and 10-cent coins. A 2-bit coin code is sampled on each rising clock edge. The state register holds the credit collected so far. A vend output is high for exactly one cycle when the credit reaches 15 cents or more.

The cycle after a vend also begins the next purchase. A coin that arrives while vend is high is counted as the first coin of a new credit. If no coin arrives, the credit drops to zero. The `CHANGE_EN` parameter sets the build-time mode. In the base mode any overpayment is kept. In the change mode the register widens to three bits and gains a 20-cent state, in which the change output is raised alongside vend.

Top module: `vend_credit_fsm`

## Requirements
- R1: When `rst` is high at a rising edge, the credit returns to zero. After that edge, `vend` and `change` are both low, whatever the coin code is.
- R2: Code 2'b01 is a 5-cent coin, 2'b10 is a 10-cent coin and 2'b00 is no coin. With no coin, a credit of 0, 5 or 10 cents holds its value.
- R3: Code 2'b11 is illegal and behaves exactly like no coin. In particular, a credit of 5 or 10 cents stays the same.
- R4: `vend` is a registered Moore output. It goes high in the cycle after the coin that brings the credit to 15 cents or more, and it is low whenever the credit is below 15 cents.
- R5: From the vend state, a cycle with no coin or the illegal code returns the credit to zero, so `vend` is low one cycle later.
- R6: A coin seen while `vend` is high starts a new credit. A 5-cent coin sets the credit to 5 cents and a 10-cent coin sets it to 10 cents. `vend` is low in the following cycle.
- R7: When `CHANGE_EN`=0, a 10-cent coin on a 10-cent credit raises `vend` only. The extra 5 cents is kept, and `change` is never high.
- R8: When `CHANGE_EN`=1, a 10-cent coin on a 10-cent credit enters a 20-cent state in which `vend` and `change` are both high. `change` is low in every other state.
- R9: The 20-cent state is left on the next edge in the same way as the 15-cent state: no coin goes to 0, a 5-cent coin goes to 5 cents and a 10-cent coin goes to 10 cents.
- R10: Each of the coin sequences 5+5+5, 5+10 and 10+5 reaches exactly 15 cents, raising `vend` with `change` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_code | input | 2 | Coin seen this cycle: 00 none, 01 five cents, 10 ten cents, 11 illegal |
| vend | output | 1 | High while the credit is 15 cents or more |
| change | output | 1 | High in the 20-cent state (change mode only) |

## Verification
Both outputs are decoded directly from the state register, so a wrong next-state choice shows at the ports one edge after the coin that caused it. A wrong credit below 15 cents stays hidden until later coins either reach the price too early or fail to reach it. For this reason the stimulus always follows a suspect transition with further coins, so the error surfaces as a vend in the wrong cycle.

An exit from the vend state to the wrong credit shows the same way: the next vend arrives one coin too early or too late. The bench runs both modes side by side on the same coin stream, so any difference between the 15-cent and 20-cent paths appears in the same cycle.

// File: rtl/vend_pkg.sv
package vend_pkg;

   // Coin codes sampled on coin_code
   localparam logic [1:0] COIN_NONE  = 2'b00;
   localparam logic [1:0] COIN_NICK  = 2'b01;
   localparam logic [1:0] COIN_DIME  = 2'b10;
   localparam logic [1:0] COIN_BAD   = 2'b11;

   // Credit state codes; the low two bits match in both modes
   localparam int unsigned CR_ZERO = 0;
   localparam int unsigned CR_FIVE = 1;
   localparam int unsigned CR_TEN  = 2;
   localparam int unsigned CR_FULL = 3;
   localparam int unsigned CR_OVER = 4;

   typedef struct packed {
      logic nickel;
      logic dime;
   } coin_t;

   function automatic int unsigned state_width(input int unsigned chg_en);
      return (chg_en != 0) ? 3 : 2;
   endfunction

endpackage

// File: rtl/vend_coin_dec.sv
module vend_coin_dec
   import vend_pkg::*;
(
   input  logic [1:0] coin_code,
   output coin_t      coin
);
   always_comb begin
      coin = '0;
      unique case (coin_code)
         COIN_NICK: coin.nickel = 1'b1;
         COIN_DIME: coin.dime   = 1'b1;
         default:   coin        = '0;   // none and illegal code
      endcase
   end
endmodule

// File: rtl/vend_credit_next.sv
module vend_credit_next
   import vend_pkg::*;
#(
   parameter int unsigned CHANGE_EN = 0,
   parameter int unsigned SW        = 2
) (
   input  logic [SW-1:0] cur,
   input  coin_t         coin,
   output logic [SW-1:0] nxt
);
   localparam logic [SW-1:0] S_ZERO = SW'(CR_ZERO);
   localparam logic [SW-1:0] S_FIVE = SW'(CR_FIVE);
   localparam logic [SW-1:0] S_TEN  = SW'(CR_TEN);
   localparam logic [SW-1:0] S_FULL = SW'(CR_FULL);

   logic [SW-1:0] ten_plus_dime;
   logic          at_vend;

   generate
      if (CHANGE_EN != 0) begin : g_chg
         localparam logic [SW-1:0] S_OVER = SW'(CR_OVER);
         assign ten_plus_dime = S_OVER;
         assign at_vend       = (cur == S_FULL) || (cur == S_OVER);
      end else begin : g_base
         assign ten_plus_dime = S_FULL;
         assign at_vend       = (cur == S_FULL);
      end
   endgenerate

   always_comb begin
      nxt = S_ZERO;
      if (at_vend) begin
         if (coin.nickel)    nxt = S_FIVE;
         else if (coin.dime) nxt = S_TEN;
         else                nxt = S_ZERO;
      end else if (cur == S_ZERO) begin
         if (coin.nickel)    nxt = S_FIVE;
         else if (coin.dime) nxt = S_TEN;
         else                nxt = S_ZERO;
      end else if (cur == S_FIVE) begin
         if (coin.nickel)    nxt = S_TEN;
         else if (coin.dime) nxt = S_FULL;
         else                nxt = S_FIVE;
      end else if (cur == S_TEN) begin
         if (coin.nickel)    nxt = S_FULL;
         else if (coin.dime) nxt = ten_plus_dime;
         else                nxt = S_TEN;
      end else begin
         nxt = S_ZERO;   // unused codes recover to zero credit
      end
   end
endmodule

// File: rtl/vend_out_dec.sv
module vend_out_dec
   import vend_pkg::*;
#(
   parameter int unsigned CHANGE_EN = 0,
   parameter int unsigned SW        = 2
) (
   input  logic [SW-1:0] st,
   output logic          vend,
   output logic          change
);
   localparam logic [SW-1:0] S_FULL = SW'(CR_FULL);

   generate
      if (CHANGE_EN != 0) begin : g_chg
         localparam logic [SW-1:0] S_OVER = SW'(CR_OVER);
         assign change = (st == S_OVER);
         assign vend   = (st == S_FULL) || (st == S_OVER);
      end else begin : g_base
         assign change = 1'b0;
         assign vend   = (st == S_FULL);
      end
   endgenerate
endmodule

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm
   import vend_pkg::*;
#(
   parameter int unsigned CHANGE_EN = 0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] coin_code,
   output logic       vend,
   output logic       change
);
   localparam int unsigned SW = state_width(CHANGE_EN);

   generate
      if (CHANGE_EN > 1) begin : g_bad_param
         $error("vend_credit_fsm: CHANGE_EN must be 0 or 1");
      end
   endgenerate

   coin_t         coin;
   logic [SW-1:0] state_q;
   logic [SW-1:0] state_d;

   vend_coin_dec u_dec (
      .coin_code (coin_code),
      .coin      (coin)
   );

   vend_credit_next #(.CHANGE_EN(CHANGE_EN), .SW(SW)) u_next (
      .cur  (state_q),
      .coin (coin),
      .nxt  (state_d)
   );

   always_ff @(posedge clk) begin
      if (rst) state_q <= '0;
      else     state_q <= state_d;
   end

   vend_out_dec #(.CHANGE_EN(CHANGE_EN), .SW(SW)) u_out (
      .st     (state_q),
      .vend   (vend),
      .change (change)
   );
endmodule

// File: rtl/vend_credit_chk.sv
module vend_credit_chk #(
   parameter int unsigned CHANGE_EN = 0,
   parameter int unsigned SW        = 2
) (
   input logic          clk,
   input logic          rst,
   input logic [1:0]    coin_code,
   input logic          vend,
   input logic          change,
   input logic [SW-1:0] state_q
);
   // R5
   vend_exit_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (vend && (coin_code == 2'b00 || coin_code == 2'b11)) |=> (!vend && !change && state_q == '0));

   // R6
   vend_restart_nick_chk: assert property (@(posedge clk) disable iff (rst)
      (vend && coin_code == 2'b01) |=> (!vend && state_q == SW'(1)));

   // R6
   vend_restart_dime_chk: assert property (@(posedge clk) disable iff (rst)
      (vend && coin_code == 2'b10) |=> (!vend && state_q == SW'(2)));

   // R3
   bad_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!vend && coin_code == 2'b11) |=> $stable(state_q));

   // R4
   vend_needs_coin_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(vend) |-> ($past(coin_code) == 2'b01 || $past(coin_code) == 2'b10));

   // R8
   change_with_vend_chk: assert property (@(posedge clk) disable iff (rst)
      change |-> vend);

   // R2
   zero_nick_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == '0 && coin_code == 2'b01) |=> (state_q == SW'(1)));
endmodule

bind vend_credit_fsm vend_credit_chk #(.CHANGE_EN(CHANGE_EN), .SW(SW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .coin_code (coin_code),
   .vend      (vend),
   .change    (change),
   .state_q   (state_q)
);

// File: tb/sim_vend_credit_fsm.sv
module sim_vend_credit_fsm;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 22;

   // {coin[1:0], exp vend chg-mode, exp change chg-mode, exp vend base-mode}
   localparam logic [4:0] VEC [NVEC] = '{
      5'b01_0_0_0, // R2 5
      5'b00_0_0_0, // R2 hold 5
      5'b11_0_0_0, // R3 illegal holds 5
      5'b01_0_0_0, // R10 10
      5'b01_1_0_1, // R10 5+5+5 = 15
      5'b00_0_0_0, // R5 back to 0
      5'b10_0_0_0, // 10
      5'b10_1_1_1, // R8 20 / R7 base keeps overpay
      5'b10_0_0_0, // R9 exit 20 with dime -> 10
      5'b01_1_0_1, // R10 10+5
      5'b01_0_0_0, // R6 new credit 5
      5'b10_1_0_1, // R10 5+10
      5'b11_0_0_0, // R5 illegal in vend -> 0
      5'b10_0_0_0, // 10
      5'b10_1_1_1, // R8 20
      5'b01_0_0_0, // R9 exit 20 with nickel -> 5
      5'b10_1_0_1, // 15
      5'b10_0_0_0, // R6 new credit 10
      5'b11_0_0_0, // R3 illegal holds 10
      5'b00_0_0_0, // R2 hold 10
      5'b01_1_0_1, // 15
      5'b00_0_0_0  // R5 back to 0
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] coin = 2'b00;
   logic       vend_c, change_c, vend_b, change_b;
   int         tests = 0;
   int         fails = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vend_credit_fsm #(.CHANGE_EN(1)) u0 (
      .clk(clk), .rst(rst), .coin_code(coin), .vend(vend_c), .change(change_c));

   vend_credit_fsm #(.CHANGE_EN(0)) u1 (
      .clk(clk), .rst(rst), .coin_code(coin), .vend(vend_b), .change(change_b));

   task automatic chk(input string req, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
      end
   endtask

   // drive at a falling edge, check at the next falling edge
   task automatic step(input logic [1:0] c, input logic r);
      coin = c;
      rst  = r;
      @(negedge clk);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      chk("R1 reset vend chg", vend_c, 1'b0);
      chk("R1 reset change",   change_c, 1'b0);
      chk("R1 reset vend base", vend_b, 1'b0);
      rst = 1'b0;

      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][4:3], 1'b0);
         chk($sformatf("R4 R8 row %0d vend chg", i),  vend_c,   VEC[i][2]);
         chk($sformatf("R8 row %0d change chg", i),   change_c, VEC[i][1]);
         chk($sformatf("R4 R7 row %0d vend base", i), vend_b,   VEC[i][0]);
         chk($sformatf("R7 row %0d change base", i),  change_b, 1'b0);
      end

      // R1: reset with a coin present, from a 10-cent credit
      step(2'b10, 1'b0);
      step(2'b01, 1'b1);
      chk("R1 reset beats coin vend", vend_c, 1'b0);
      step(2'b01, 1'b0);
      chk("R1 after reset 5 no vend", vend_c, 1'b0);
      step(2'b10, 1'b0);
      chk("R1 after reset 15 vend", vend_c, 1'b1);
      chk("R1 after reset 15 change", change_c, 1'b0);

      // R1: reset out of the 20-cent state
      step(2'b10, 1'b0);
      step(2'b10, 1'b0);
      chk("R8 reach 20 change", change_c, 1'b1);
      step(2'b10, 1'b1);
      chk("R1 reset from 20 vend", vend_c, 1'b0);
      chk("R1 reset from 20 change", change_c, 1'b0);
      step(2'b00, 1'b0);
      chk("R1 held zero after reset", vend_b, 1'b0);
      step(2'b10, 1'b0);
      step(2'b01, 1'b0);
      chk("R10 10+5 after reset base", vend_b, 1'b1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule